// File: doc/BRIEF.md
# Self-Purging Hybrid Switch-Voter

This block sits behind a set of replicated modules that compute the same word. Each cycle it takes the word from every module and forms a weighted word vote. A module has weight one while it is live and weight zero once it is purged or held back as a spare. The voted word is registered and driven out, so a faulty minority is masked. The block also compares every live module against the voted word. A module that keeps disagreeing is removed for good.

The removal policy is set by a parameter. In hybrid mode only the first `N_ACT` modules start live, and the remaining `N_SPARE` modules wait in a pool. Each purged module is replaced by the lowest-numbered spare still in the pool. When the pool is empty, the block runs as plain static redundancy. In self-purging mode every module starts live and no replacement takes place. In both modes, the threshold is a strict majority of the live count, and it follows that count as modules drop out. When no word reaches the threshold, for example two survivors that differ, the block raises a flag and holds its output.

Top module: `redund_voter`

## Requirements
- R1: During and right after reset: `vote_out` is 0, and `purged`, `degraded` and `unresolved` are all low. In hybrid mode modules 0 to N_ACT-1 are live and the rest are spares. In self-purging mode all modules are live.
- R2: Module i presents its word on `mod_data[i*W +: W]`. When a word is held by a number of live modules whose double exceeds the live count, that word appears on `vote_out` one clock edge after it is presented.
- R3: A purged module, or a spare that has not been promoted, has no influence on `vote_out`.
- R4: A live module is purged at the edge that completes `PURGE_RUN` consecutive cycles in which it differs from a valid majority. One agreeing cycle resets its run, so a shorter transient leaves `purged` unchanged.
- R5: In hybrid mode, each purged module is replaced at the same edge by the lowest-indexed spare left in the pool. `degraded` stays low while replacements exist.
- R6: `degraded` is high exactly when the live count is below its starting value: N_ACT in hybrid mode, and all modules in self-purging mode.
- R7: When no word reaches a strict majority, `unresolved` goes high at that edge and `vote_out` keeps its previous value. No module is purged, and the disagreement runs do not advance. The next valid majority clears `unresolved`.
- R8: A bit set in `purged` stays set until reset.
- R9: After a purge, the majority threshold is recomputed from the new live count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mod_data | input | (N_ACT+N_SPARE)*W | Packed words of all modules, module i at bits i*W +: W |
| vote_out | output | W | Registered majority word |
| purged | output | N_ACT+N_SPARE | One bit per module that has been removed |
| degraded | output | 1 | Live count below its starting value |
| unresolved | output | 1 | No strict majority in the last voted cycle; output held |

## Verification
The properties assume only that `mod_data` is a known value at each rising edge. They make no assumption about how many modules are faulty. As a result they hold both when a majority exists and when the live set splits evenly. The stimulus changes `mod_data` only on falling edges. It builds deliberate disagreement patterns: isolated transients, runs of exactly `PURGE_RUN` cycles, and even splits that last longer than a purge run. These patterns reach the hold-and-flag path as well as the purge and spare-promotion paths.

// File: rtl/rv_pkg.sv
package rv_pkg;
   typedef enum logic {
      RV_HYBRID     = 1'b0,
      RV_SELF_PURGE = 1'b1
   } rv_mode_e;
endpackage

// File: rtl/rv_vote.sv
// Weighted word voter: a live module carries weight one, any other weight zero.
module rv_vote #(
   parameter int NM = 5,
   parameter int W  = 8
) (
   input  logic [NM*W-1:0] words,
   input  logic [NM-1:0]   live,
   output logic            maj_ok,
   output logic [W-1:0]    maj_word,
   output logic [NM-1:0]   dis
);
   localparam int CW = $clog2(NM + 1);

   logic [CW-1:0] live_cnt;
   logic [CW-1:0] agree_cnt;

   always_comb begin
      live_cnt = '0;
      for (int i = 0; i < NM; i++)
         live_cnt = live_cnt + CW'(live[i]);
      maj_ok    = 1'b0;
      maj_word  = '0;
      agree_cnt = '0;
      // walk downward so the lowest-indexed majority holder wins
      for (int i = NM - 1; i >= 0; i--) begin
         agree_cnt = '0;
         for (int j = 0; j < NM; j++)
            if (live[j] && (words[j*W +: W] == words[i*W +: W]))
               agree_cnt = agree_cnt + CW'(1);
         if (live[i] && ({agree_cnt, 1'b0} > {1'b0, live_cnt})) begin
            maj_ok   = 1'b1;
            maj_word = words[i*W +: W];
         end
      end
   end

   for (genvar g = 0; g < NM; g++) begin : g_dis
      assign dis[g] = live[g] & maj_ok & (words[g*W +: W] != maj_word);
   end
endmodule

// File: rtl/rv_diag.sv
// Per-module disagreement run counters; a run of RUN cycles requests a purge.
module rv_diag #(
   parameter int NM  = 5,
   parameter int RUN = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NM-1:0] live,
   input  logic          maj_ok,
   input  logic [NM-1:0] dis,
   output logic [NM-1:0] purge
);
   localparam int RW = (RUN > 1) ? $clog2(RUN) : 1;

   for (genvar g = 0; g < NM; g++) begin : g_run
      logic [RW-1:0] run_q;

      assign purge[g] = dis[g] && (run_q == RW'(RUN - 1));

      always_ff @(posedge clk) begin
         if (!rst_n)          run_q <= '0;
         else if (!live[g])   run_q <= '0;
         else if (!maj_ok)    run_q <= run_q;
         else if (purge[g])   run_q <= '0;
         else if (dis[g])     run_q <= run_q + RW'(1);
         else                 run_q <= '0;
      end
   end
endmodule

// File: rtl/rv_switch.sv
// Weight register and reconfiguration: spare promotion or plain purging.
module rv_switch #(
   parameter int NM     = 5,
   parameter int N_ACT  = 3,
   parameter bit HYBRID = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NM-1:0] purge,
   output logic [NM-1:0] live,
   output logic [NM-1:0] purged,
   output logic          degraded
);
   localparam int CW  = $clog2(NM + 1);
   localparam int TGT = HYBRID ? N_ACT : NM;

   logic [NM-1:0] live_q, purged_q;
   logic [CW-1:0] live_cnt;

   if (HYBRID) begin : g_hybrid
      localparam logic [NM-1:0] INIT_LIVE = ({NM{1'b1}} >> (NM - N_ACT));
      logic [NM-1:0] pool_q, pool_d, live_d;
      logic [CW-1:0] need;

      always_comb begin
         need   = CW'($countones(purge));
         live_d = live_q & ~purge;
         pool_d = pool_q;
         for (int i = 0; i < NM; i++) begin
            if (pool_q[i] && (need != '0)) begin
               live_d[i] = 1'b1;
               pool_d[i] = 1'b0;
               need      = need - CW'(1);
            end
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            live_q <= INIT_LIVE;
            pool_q <= ~INIT_LIVE;
         end else begin
            live_q <= live_d;
            pool_q <= pool_d;
         end
      end
   end else begin : g_purge
      always_ff @(posedge clk) begin
         if (!rst_n) live_q <= '1;
         else        live_q <= live_q & ~purge;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) purged_q <= '0;
      else        purged_q <= purged_q | purge;
   end

   always_comb begin
      live_cnt = '0;
      for (int i = 0; i < NM; i++)
         live_cnt = live_cnt + CW'(live_q[i]);
   end

   assign live     = live_q;
   assign purged   = purged_q;
   assign degraded = (live_cnt < CW'(TGT));
endmodule

// File: rtl/redund_voter.sv
module redund_voter #(
   parameter int             N_ACT     = 3,
   parameter int             N_SPARE   = 2,
   parameter int             W         = 8,
   parameter int             PURGE_RUN = 2,
   parameter rv_pkg::rv_mode_e MODE    = rv_pkg::RV_HYBRID
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [(N_ACT+N_SPARE)*W-1:0] mod_data,
   output logic [W-1:0]                 vote_out,
   output logic [N_ACT+N_SPARE-1:0]     purged,
   output logic                         degraded,
   output logic                         unresolved
);
   localparam int NM     = N_ACT + N_SPARE;
   localparam bit HYBRID = (MODE == rv_pkg::RV_HYBRID);

   if (N_ACT < 1)     begin : g_bad_act  $error("N_ACT must be at least 1");  end
   if (N_SPARE < 0)   begin : g_bad_spr  $error("N_SPARE must not be negative"); end
   if (W < 1)         begin : g_bad_w    $error("W must be at least 1");      end
   if (PURGE_RUN < 1) begin : g_bad_run  $error("PURGE_RUN must be at least 1"); end

   logic [NM-1:0] live, dis, purge;
   logic          maj_ok;
   logic [W-1:0]  maj_word;

   rv_vote #(.NM(NM), .W(W)) u_vote (
      .words(mod_data), .live(live),
      .maj_ok(maj_ok), .maj_word(maj_word), .dis(dis)
   );

   rv_diag #(.NM(NM), .RUN(PURGE_RUN)) u_diag (
      .clk(clk), .rst_n(rst_n), .live(live),
      .maj_ok(maj_ok), .dis(dis), .purge(purge)
   );

   rv_switch #(.NM(NM), .N_ACT(N_ACT), .HYBRID(HYBRID)) u_switch (
      .clk(clk), .rst_n(rst_n), .purge(purge),
      .live(live), .purged(purged), .degraded(degraded)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vote_out   <= '0;
         unresolved <= 1'b0;
      end else if (maj_ok) begin
         vote_out   <= maj_word;
         unresolved <= 1'b0;
      end else begin
         unresolved <= 1'b1;
      end
   end
endmodule

// File: rtl/rv_chk.sv
module rv_chk #(
   parameter int NM    = 5,
   parameter int W     = 8,
   parameter int SLACK = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic [W-1:0]  vote_out,
   input logic [NM-1:0] purged,
   input logic          degraded,
   input logic          unresolved
);
   // R8
   purge_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((purged & $past(purged)) == $past(purged)));

   // R7
   hold_on_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unresolved |-> (vote_out == $past(vote_out)));

   // R7
   no_purge_on_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unresolved |-> (purged == $past(purged)));

   // R6
   degraded_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      degraded == ($countones(purged) > SLACK));

   // R4
   survivor_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(purged) < NM);
endmodule

bind redund_voter rv_chk #(
   .NM(N_ACT + N_SPARE), .W(W),
   .SLACK((MODE == rv_pkg::RV_HYBRID) ? N_SPARE : 0)
) u_chk (
   .clk(clk), .rst_n(rst_n), .vote_out(vote_out), .purged(purged),
   .degraded(degraded), .unresolved(unresolved)
);

// File: tb/redund_voter_bench.sv
`timescale 1ns/1ps
module redund_voter_bench;
   localparam int W  = 8;
   localparam int NM = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NM*W-1:0] hy_data = '0, sp_data = '0;
   logic [W-1:0]  hy_vote, sp_vote;
   logic [NM-1:0] hy_purged, sp_purged;
   logic hy_deg, sp_deg, hy_unr, sp_unr;

   int checks = 0, fails = 0;

   always #2 clk = ~clk;

   redund_voter #(.N_ACT(3), .N_SPARE(2), .W(W), .PURGE_RUN(2),
                  .MODE(rv_pkg::RV_HYBRID)) u_redund_voter (
      .clk(clk), .rst_n(rst_n), .mod_data(hy_data), .vote_out(hy_vote),
      .purged(hy_purged), .degraded(hy_deg), .unresolved(hy_unr));

   redund_voter #(.N_ACT(3), .N_SPARE(2), .W(W), .PURGE_RUN(2),
                  .MODE(rv_pkg::RV_SELF_PURGE)) u_redund_voter_sp (
      .clk(clk), .rst_n(rst_n), .mod_data(sp_data), .vote_out(sp_vote),
      .purged(sp_purged), .degraded(sp_deg), .unresolved(sp_unr));

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [NM*W-1:0] pack(logic [W-1:0] m0, logic [W-1:0] m1,
                                            logic [W-1:0] m2, logic [W-1:0] m3,
                                            logic [W-1:0] m4);
      return {m4, m3, m2, m1, m0};
   endfunction

   task automatic hy_step(logic [NM*W-1:0] d);
      hy_data = d;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic sp_step(logic [NM*W-1:0] d);
      sp_data = d;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset;
      check("R1 vote", hy_vote, 0);
      check("R1 purged", hy_purged, 0);
      check("R1 degraded", hy_deg, 0);
      check("R1 unresolved", hy_unr, 0);
      check("R1 sp purged", sp_purged, 0);
      check("R1 sp degraded", sp_deg, 0);
   endtask

   task automatic t_agree_and_transient;
      hy_step(pack(8'hA5, 8'hA5, 8'hA5, 8'h00, 8'h00));
      check("R2 all agree", hy_vote, 8'hA5);
      // R3: spares 3 and 4 disagree yet are not counted
      check("R3 spares ignored", hy_vote, 8'hA5);
      hy_step(pack(8'hA5, 8'h3C, 8'hA5, 8'h00, 8'h00));
      check("R2 masked minority", hy_vote, 8'hA5);
      hy_step(pack(8'hA5, 8'hA5, 8'hA5, 8'h00, 8'h00));
      check("R4 transient no purge", hy_purged, 0);
   endtask

   task automatic t_purge_promote;
      hy_step(pack(8'hA5, 8'h3C, 8'hA5, 8'hA5, 8'hA5));
      check("R4 run not complete", hy_purged, 0);
      hy_step(pack(8'hA5, 8'h3C, 8'hA5, 8'hA5, 8'hA5));
      check("R4 purged after run", hy_purged, 5'b00010);
      check("R5 spare keeps full", hy_deg, 0);
      // live is now {0,2,3}; purged 1 and spare 4 outvote if counted
      hy_step(pack(8'h55, 8'h66, 8'h66, 8'h55, 8'h66));
      check("R5 promoted spare 3 counts", hy_vote, 8'h55);
      check("R3 purged ignored", hy_vote, 8'h55);
      hy_step(pack(8'hA5, 8'hA5, 8'hA5, 8'hA5, 8'hA5));
      hy_step(pack(8'h0F, 8'hA5, 8'hA5, 8'hA5, 8'hA5));
      hy_step(pack(8'h0F, 8'hA5, 8'hA5, 8'hA5, 8'hA5));
      check("R5 second purge", hy_purged, 5'b00011);
      check("R5 still full", hy_deg, 0);
      // live is now {2,3,4}
      hy_step(pack(8'h77, 8'h77, 8'h77, 8'h88, 8'h88));
      check("R5 spare 4 promoted", hy_vote, 8'h88);
      check("R8 purge sticky", hy_purged, 5'b00011);
      hy_step(pack(8'hA5, 8'hA5, 8'hA5, 8'hA5, 8'hA5));
   endtask

   task automatic t_exhaust_and_split;
      hy_step(pack(8'hA5, 8'hA5, 8'h12, 8'hA5, 8'hA5));
      hy_step(pack(8'hA5, 8'hA5, 8'h12, 8'hA5, 8'hA5));
      check("R6 pool empty purge", hy_purged, 5'b00111);
      check("R6 degraded", hy_deg, 1);
      for (int k = 0; k < 3; k++) begin
         hy_step(pack(8'h00, 8'h00, 8'h00, 8'h11, 8'h22));
         check("R7 unresolved", hy_unr, 1);
         check("R7 output held", hy_vote, 8'hA5);
      end
      check("R7 no purge on split", hy_purged, 5'b00111);
      hy_step(pack(8'h00, 8'h00, 8'h00, 8'h33, 8'h33));
      check("R7 cleared", hy_unr, 0);
      check("R2 two survivors agree", hy_vote, 8'h33);
   endtask

   task automatic t_self_purge;
      sp_step(pack(8'h3C, 8'h3C, 8'h3C, 8'h3C, 8'h3C));
      check("R2 sp all agree", sp_vote, 8'h3C);
      sp_step(pack(8'h3C, 8'h3C, 8'h3C, 8'h3C, 8'hEE));
      sp_step(pack(8'h3C, 8'h3C, 8'h3C, 8'h3C, 8'hEE));
      check("R4 sp purge", sp_purged, 5'b10000);
      check("R6 sp degraded", sp_deg, 1);
      for (int k = 0; k < 3; k++)
         sp_step(pack(8'h11, 8'h11, 8'h22, 8'h22, 8'h11));
      check("R9 2-2 of four no majority", sp_unr, 1);
      check("R7 sp held", sp_vote, 8'h3C);
      check("R7 sp no purge", sp_purged, 5'b10000);
      sp_step(pack(8'h44, 8'h44, 8'h44, 8'h55, 8'h55));
      check("R9 three of four wins", sp_vote, 8'h44);
      check("R7 sp cleared", sp_unr, 0);
   endtask

   initial begin : watchdog
      #(200000 * 4);
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", hy_vote, 0);
      t_agree_and_transient();
      t_purge_promote();
      t_exhaust_and_split();
      t_self_purge();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule